// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block decides, one clock at a time, whether a new job may be launched into a static multi-stage pipeline without two jobs claiming the same stage in the same cycle. It keeps a collision vector in a register. Bit i of that vector tells whether a launch i cycles from the present would collide with work already in flight. Bit 0 stands for the current cycle. Every clock the vector moves one place toward bit 0. When a launch is granted, the fixed initial collision vector is ORed into the moved vector. That initial vector is a parameter and describes the stage usage of one job.

A requester raises a request line and chooses one of two policies. In greedy mode the request is remembered inside the block and granted at the first permitted cycle, so a pipeline that is fed steadily settles into its greedy latency cycle. In follow mode the request is only honoured in a cycle that is itself permitted. The requester must keep the line high until the grant arrives. The block also reports the live vector, the number of cycles since the last launch (saturating), and an empty flag that is set once no earlier launch still constrains the future.

Top module: `pipe_init_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the collision vector to all zeros, sets the latency output to CV_W+1, sets the empty flag and discards any remembered request.
- R2: In a cycle without a grant, the next vector is the current vector shifted one place toward bit 0: bit 0 is dropped and a 0 enters at bit CV_W-1.
- R3: In a cycle with a grant, the next vector is the shifted vector ORed with the initial collision vector parameter. The default is 6'b100101, which marks latencies 0, 2 and 5 as forbidden.
- R4: A grant is issued only when bit 1 of the current vector is 0. Bit 1 is the bit that lands in position 0 after the shift.
- R5: In greedy mode (greedy input = 1), a request that meets a forbidden cycle is held inside the block. It is granted at the earliest permitted cycle even if the request line has dropped by then.
- R6: In follow mode (greedy input = 0), a grant needs the request line high in a permitted cycle. A request that meets a forbidden cycle is not remembered.
- R7: The latency output is 1 in the cycle after a grant. It then rises by one per cycle and stops at CV_W+1.
- R8: The empty flag is 1 exactly when the vector is all zeros, and a request made from the empty state is granted in the same cycle.
- R9: With the default vector and a request held in greedy mode from the empty state, grants fall at latencies 1, 3, 3 repeating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Launch request |
| greedy_i | input | 1 | 1 = greedy (remember request), 0 = follow |
| grant_o | output | 1 | Launch granted in this cycle |
| cv_o | output | CV_W | Current collision vector, bit i = latency i |
| lat_o | output | $clog2(CV_W+2) | Cycles since last grant, saturating at CV_W+1 |
| empty_o | output | 1 | Vector is all zeros |

## Verification
A corrupted vector bit can stay hidden for several cycles. It shows up at the ports either as a grant at a forbidden latency or as a missing grant at a permitted one. The exposed vector shows the error on the very next cycle. Because of that, the bench compares the vector, the grant, the latency and the empty flag every cycle over a full greedy cycle, a drain to empty and a follow-mode run. A fault in the held-request logic only shows when a request meets a forbidden cycle. The bench therefore includes single-cycle request pulses on forbidden cycles in both modes.

// File: rtl/pipe_init_pkg.sv
package pipe_init_pkg;

    localparam int DEF_CV_W = 6;
    localparam logic [DEF_CV_W-1:0] DEF_ICV = 6'b100101;

    typedef enum logic {
        MODE_FOLLOW = 1'b0,
        MODE_GREEDY = 1'b1
    } launch_mode_e;

    typedef struct packed {
        logic permit;
        logic grant;
    } launch_ctl_t;

    function automatic int sat_latency(input int width);
        return width + 1;
    endfunction

    function automatic int lat_bits(input int width);
        return $clog2(width + 2);
    endfunction

endpackage

// File: rtl/cv_register.sv
module cv_register
    import pipe_init_pkg::*;
#(
    parameter int CV_W = DEF_CV_W,
    parameter logic [CV_W-1:0] ICV_MASK = DEF_ICV
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            grant,
    output logic [CV_W-1:0] cv_q,
    output logic            permit,
    output logic            empty
);

    logic [CV_W-1:0] advanced;
    logic [CV_W-1:0] cv_d;

    always_comb begin
        advanced = cv_q >> 1;
        permit   = ~advanced[0];
        cv_d     = grant ? (advanced | ICV_MASK) : advanced;
        empty    = (cv_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cv_q <= '0;
        else     cv_q <= cv_d;
    end

endmodule

// File: rtl/launch_arbiter.sv
module launch_arbiter
    import pipe_init_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  launch_mode_e mode,
    input  logic         req,
    input  logic         permit,
    output launch_ctl_t  ctl
);

    logic held_q;
    logic want;

    always_comb begin
        want        = req | ((mode == MODE_GREEDY) & held_q);
        ctl.permit  = permit;
        ctl.grant   = want & permit;
    end

    always_ff @(posedge clk) begin
        if (rst)                      held_q <= 1'b0;
        else if (mode == MODE_GREEDY) held_q <= want & ~ctl.grant;
        else                          held_q <= 1'b0;
    end

endmodule

// File: rtl/latency_counter.sv
module latency_counter
    import pipe_init_pkg::*;
#(
    parameter int CV_W = DEF_CV_W,
    localparam int LW  = lat_bits(CV_W),
    localparam int SAT = sat_latency(CV_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grant,
    output logic [LW-1:0] lat_q
);

    always_ff @(posedge clk) begin
        if (rst)                     lat_q <= LW'(SAT);
        else if (grant)              lat_q <= LW'(1);
        else if (lat_q != LW'(SAT))  lat_q <= lat_q + LW'(1);
    end

endmodule

// File: rtl/pipe_init_ctrl.sv
module pipe_init_ctrl
    import pipe_init_pkg::*;
#(
    parameter int CV_W = DEF_CV_W,
    parameter logic [CV_W-1:0] ICV_MASK = DEF_ICV,
    localparam int LW = lat_bits(CV_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            greedy_i,
    output logic            grant_o,
    output logic [CV_W-1:0] cv_o,
    output logic [LW-1:0]   lat_o,
    output logic            empty_o
);

    launch_ctl_t  ctl;
    launch_mode_e mode;
    logic         permit;

    assign mode = launch_mode_e'(greedy_i);

    cv_register #(.CV_W(CV_W), .ICV_MASK(ICV_MASK)) u_cv (
        .clk    (clk),
        .rst    (rst),
        .grant  (ctl.grant),
        .cv_q   (cv_o),
        .permit (permit),
        .empty  (empty_o)
    );

    launch_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .req    (req_i),
        .permit (permit),
        .ctl    (ctl)
    );

    latency_counter #(.CV_W(CV_W)) u_lat (
        .clk   (clk),
        .rst   (rst),
        .grant (ctl.grant),
        .lat_q (lat_o)
    );

    assign grant_o = ctl.grant;

endmodule

// File: rtl/pipe_init_ctrl_chk.sv
module pipe_init_ctrl_chk
    import pipe_init_pkg::*;
#(
    parameter int CV_W = DEF_CV_W,
    parameter logic [CV_W-1:0] ICV_MASK = DEF_ICV,
    localparam int LW  = lat_bits(CV_W),
    localparam int SAT = sat_latency(CV_W)
) (
    input logic            clk,
    input logic            rst,
    input logic            req_i,
    input logic            greedy_i,
    input logic            grant_o,
    input logic [CV_W-1:0] cv_o,
    input logic [LW-1:0]   lat_o,
    input logic            empty_o
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cv_o == '0 && lat_o == LW'(SAT) && empty_o));

    assert_shift_only_R2: assert property (@(posedge clk) disable iff (rst)
        !grant_o |=> cv_o == ($past(cv_o) >> 1));

    assert_or_icv_R3: assert property (@(posedge clk) disable iff (rst)
        grant_o |=> cv_o == (($past(cv_o) >> 1) | ICV_MASK));

    assert_no_collision_R4: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> !cv_o[1]);

    assert_follow_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
        (!greedy_i && !req_i) |-> !grant_o);

    assert_lat_restart_R7: assert property (@(posedge clk) disable iff (rst)
        grant_o |=> lat_o == LW'(1));

    assert_lat_count_R7: assert property (@(posedge clk) disable iff (rst)
        (!grant_o && lat_o != LW'(SAT)) |=> lat_o == $past(lat_o) + LW'(1));

    assert_empty_flag_R8: assert property (@(posedge clk) disable iff (rst)
        empty_o == (cv_o == '0));

    assert_empty_grants_R8: assert property (@(posedge clk) disable iff (rst)
        (empty_o && req_i) |-> grant_o);

endmodule

bind pipe_init_ctrl pipe_init_ctrl_chk #(.CV_W(CV_W), .ICV_MASK(ICV_MASK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .greedy_i (greedy_i),
    .grant_o  (grant_o),
    .cv_o     (cv_o),
    .lat_o    (lat_o),
    .empty_o  (empty_o)
);

// File: tb/sim_pipe_init_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_init_ctrl;

    localparam int W  = 6;
    localparam int LW = 3;
    localparam int N  = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_i = 1'b0;
    logic          greedy_i = 1'b1;
    logic          grant_o;
    logic [W-1:0]  cv_o;
    logic [LW-1:0] lat_o;
    logic          empty_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pipe_init_ctrl u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .greedy_i(greedy_i),
        .grant_o(grant_o), .cv_o(cv_o), .lat_o(lat_o), .empty_o(empty_o)
    );

    // fields: [11] greedy, [10] req, [9] expected grant, [8:6] expected latency, [5:0] expected vector
    localparam logic [11:0] VEC [N] = '{
        12'b1_1_1_111_000000,  // c0  empty, first launch (R8)
        12'b1_1_1_001_100101,  // c1  latency 1 (R9)
        12'b1_1_0_001_110111,
        12'b1_1_0_010_011011,
        12'b1_1_1_011_001101,  // c4  latency 3
        12'b1_1_0_001_100111,
        12'b1_1_0_010_010011,
        12'b1_1_1_011_001001,  // c7  latency 3
        12'b1_1_1_001_100101,  // c8  latency 1, cycle repeats
        12'b1_0_0_001_110111,
        12'b1_0_0_010_011011,
        12'b1_0_0_011_001101,
        12'b1_0_0_100_000110,
        12'b1_1_0_101_000011,  // c13 pulse on forbidden cycle, held (R5)
        12'b1_0_1_110_000001,  // c14 held request granted
        12'b1_0_0_001_100101,
        12'b1_0_0_010_010010,
        12'b1_0_0_011_001001,
        12'b1_0_0_100_000100,
        12'b1_0_0_101_000010,
        12'b1_0_0_110_000001,
        12'b1_0_0_111_000000,  // drained, latency saturated
        12'b1_0_0_111_000000,
        12'b0_1_1_111_000000,  // c23 follow mode from empty
        12'b0_0_0_001_100101,
        12'b0_1_0_010_010010,  // c25 pulse on forbidden cycle (R6)
        12'b0_0_0_011_001001,  // c26 permitted, but nothing remembered
        12'b0_0_0_100_000100,
        12'b0_1_0_101_000010,
        12'b0_1_1_110_000001,  // c29 held line granted when permitted
        12'b0_0_0_001_100101
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 vector", 32'(cv_o), 32'd0);
        check("R1 latency", 32'(lat_o), 32'd7);
        check("R1 empty", 32'(empty_o), 32'd1);

        for (int i = 0; i < N; i++) begin
            string gtag;
            greedy_i = VEC[i][11];
            req_i    = VEC[i][10];
            #1;
            if (i <= 8)       gtag = "R9/R4 grant";
            else if (i <= 22) gtag = "R5 grant";
            else              gtag = "R6 grant";
            check(gtag, 32'(grant_o), 32'(VEC[i][9]));
            check("R2/R3 vector", 32'(cv_o), 32'(VEC[i][5:0]));
            check("R7 latency", 32'(lat_o), 32'(VEC[i][8:6]));
            check("R8 empty", 32'(empty_o), 32'(VEC[i][5:0] == 6'd0));
            @(negedge clk);
        end

        // greedy request meets a forbidden cycle, then reset must drop it
        greedy_i = 1'b1;
        req_i = 1'b1;
        #1;
        check("R4 grant", 32'(grant_o), 32'd0);
        @(negedge clk);
        rst = 1'b1;
        req_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 grant", 32'(grant_o), 32'd0);
        check("R1 vector", 32'(cv_o), 32'd0);
        check("R1 latency", 32'(lat_o), 32'd7);
        @(negedge clk);
        #1;
        check("R1 held dropped", 32'(grant_o), 32'd0);

        done = 1'b1;
        summary();
    end

endmodule